// File: doc/BRIEF.md
# Cascaded Successive Running-Sum Integrator

This block keeps twelve moving-window sums of one detector's sample stream at the same time. Each window is kept up to date with a delay-and-subtract accumulator. On every new entry, the accumulator adds the newest value and subtracts the value that is leaving a tapped delay line of fixed depth. The depth of the tap sets the window.

The block does not store millions of raw samples for the long windows. It uses five short delay-line stages in cascade. The first stage holds raw samples. Every later stage holds partial sums that an earlier stage has already produced. A stage takes in a new entry only once its feeding sum covers a block of samples that is completely new, so the stored partial sums never overlap. Each stage has two taps, and the two taps serve two windows. Each window has its own update strobe, so a downstream comparator sees every new value exactly once. All depths are parameters, and a simulation can scale them down.

Top module: `srs_cascade`

## Requirements
- R1: After reset, all twelve sums read zero and no update strobe is high until the first accepted sample has been registered.
- R2: Sums 0 to 3 cover the last T1A, T1B, T1C and T1D raw samples (default 1, 2, 8 and 16). Each is updated in the clock after every accepted sample. Samples older than reset count as zero.
- R3: Sums 4 and 5 cover T1B·T2A and T1B·T2B samples (default 64 and 256). They are updated one clock after sum 1, on every T1B-th accepted sample only. Their input is the value of sum 1, so each stored entry is a block of T1B samples that do not overlap.
- R4: Sums 6 and 7 are built from entries of sum 4. They cover T2A·T1B times T3A and T3B samples (default 2048 and 16384). They are updated every T1B·T2A samples, one clock after sum 4.
- R5: Sums 8 and 9 are built from entries of sum 6. They cover span(6) times T4A and T4B samples (default 32768 and 131072). They are updated every span(6) samples, one clock after sum 6.
- R6: Sums 10 and 11 are built from entries of sum 7. They cover span(7) times T5A and T5B samples (default 524288 and 2097152). They are updated every span(7) samples, one clock after sum 7.
- R7: Each update strobe is high for exactly one clock per new value. A sum holds its value in every clock in which its strobe is low.
- R8: While the sample valid input is low, the sample value input has no effect on any sum or strobe.
- R9: All arithmetic is two's complement. Each sum is DW + clog2(largest span) + 1 bits wide, so a full window of the most negative or most positive sample is represented exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all delay lines, accumulators and gate counters |
| smp_vld | input | 1 | A new sample is present this clock |
| smp_val | input | DW | Signed sample value |
| win_sum | output | 12 x SW | Signed window sums; index 0 is the shortest window, index 11 the longest |
| win_upd | output | 12 | One-clock strobe per sum, high in the clock in which the matching win_sum holds a new value |

## Verification
The integrator is driven in four ways. A long run of the most negative sample followed by a run of the most positive sample fills every window to its limit, which exposes sign and width faults. An idle stretch with random values on the sample input, while valid stays low, shows whether ignored data leaks into the sums. Constrained-random traffic has gaps of random length between valid samples. Since every stage counts accepted entries and not clocks, this traffic separates a correct block alignment, cascade latency and gate ratio from designs that work only under back-to-back input. Every strobe is compared with a reference that sums the recorded samples over the window's span, and the clock in which the strobe appears is checked against the stage's latency.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int NSUM   = 12;
    localparam int NSTAGE = 5;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Select one of up to four tap depths by index.
    function automatic int pick_tap(input int idx, input int a, input int b,
                                    input int c, input int d);
        case (idx)
            0:       return a;
            1:       return b;
            2:       return c;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/srs_delay_line.sv
module srs_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 4
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                din,
    output logic [DEPTH-1:0][W-1:0]     line
);

    // Entry 0 is the newest value; entry DEPTH-1 the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= '0;
        end else if (push) begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                line[i] <= line[i-1];
            end
        end
    end

endmodule

// File: rtl/srs_window_acc.sv
module srs_window_acc #(
    parameter int W = 16
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld,
    input  logic signed [W-1:0] newest,
    input  logic signed [W-1:0] oldest,
    output logic signed [W-1:0] sum,
    output logic                upd
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
            upd <= 1'b0;
        end else begin
            upd <= vld;
            if (vld) begin
                sum <= sum + newest - oldest;
            end
        end
    end

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(sum));

endmodule

// File: rtl/srs_feed_gate.sv
module srs_feed_gate #(
    parameter int W     = 16,
    parameter int RATIO = 2
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_upd,
    input  logic [W-1:0] in_sum,
    output logic         out_vld,
    output logic [W-1:0] out_val
);

    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt;

    // Count refreshes of the feeding sum; release it once it has been fully renewed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (in_upd) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign out_vld = in_upd && (cnt == LAST);
    assign out_val = in_sum;

    // R3
    gate_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

endmodule

// File: rtl/srs_stage.sv
module srs_stage
    import srs_pkg::*;
#(
    parameter int W    = 16,
    parameter int NTAP = 2,
    parameter int TA   = 1,
    parameter int TB   = 2,
    parameter int TC   = 1,
    parameter int TD   = 1
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [W-1:0]             in_val,
    output logic [NTAP-1:0][W-1:0]   sums,
    output logic [NTAP-1:0]          upds
);

    localparam int DEPTH = (NTAP > 2) ? imax(imax(TA, TB), imax(TC, TD))
                                      : imax(TA, TB);

    logic [DEPTH-1:0][W-1:0] line;

    srs_delay_line #(.W(W), .DEPTH(DEPTH)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_vld),
        .din   (in_val),
        .line  (line)
    );

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        localparam int TL = pick_tap(t, TA, TB, TC, TD);
        srs_window_acc #(.W(W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (in_vld),
            .newest (in_val),
            .oldest (line[TL-1]),
            .sum    (sums[t]),
            .upd    (upds[t])
        );
    end

endmodule

// File: rtl/srs_cascade.sv
module srs_cascade
    import srs_pkg::*;
#(
    parameter int DW  = 16,
    parameter int T1A = 1,
    parameter int T1B = 2,
    parameter int T1C = 8,
    parameter int T1D = 16,
    parameter int T2A = 32,
    parameter int T2B = 128,
    parameter int T3A = 32,
    parameter int T3B = 256,
    parameter int T4A = 16,
    parameter int T4B = 64,
    parameter int T5A = 32,
    parameter int T5B = 128,
    localparam int SPAN4 = T1B * T2A,
    localparam int SPAN6 = SPAN4 * T3A,
    localparam int SPAN7 = SPAN4 * T3B,
    localparam int SPAN_MAX = imax(imax(imax(T1C, T1D), T1B * T2B),
                                   imax(imax(SPAN7, SPAN6 * T4B), SPAN7 * T5B)),
    localparam int SW = DW + $clog2(SPAN_MAX) + 1
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_vld,
    input  logic signed [DW-1:0]         smp_val,
    output logic [NSUM-1:0][SW-1:0]      win_sum,
    output logic [NSUM-1:0]              win_upd
);

    logic [SW-1:0] smp_ext;
    assign smp_ext = {{(SW-DW){smp_val[DW-1]}}, smp_val};

    logic [3:0][SW-1:0] s1_sum;
    logic [3:0]         s1_upd;
    logic [1:0][SW-1:0] s2_sum, s3_sum, s4_sum, s5_sum;
    logic [1:0]         s2_upd, s3_upd, s4_upd, s5_upd;
    logic               g2_vld, g3_vld, g4_vld, g5_vld;
    logic [SW-1:0]      g2_val, g3_val, g4_val, g5_val;

    // Stage 1: raw samples.
    srs_stage #(.W(SW), .NTAP(4), .TA(T1A), .TB(T1B), .TC(T1C), .TD(T1D)) u_st1 (
        .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .in_val(smp_ext),
        .sums(s1_sum), .upds(s1_upd)
    );

    // Stage 2: blocks of T1B samples, taken from sum 1.
    srs_feed_gate #(.W(SW), .RATIO(T1B)) u_g2 (
        .clk(clk), .rst_n(rst_n), .in_upd(s1_upd[1]), .in_sum(s1_sum[1]),
        .out_vld(g2_vld), .out_val(g2_val)
    );
    srs_stage #(.W(SW), .NTAP(2), .TA(T2A), .TB(T2B), .TC(1), .TD(1)) u_st2 (
        .clk(clk), .rst_n(rst_n), .in_vld(g2_vld), .in_val(g2_val),
        .sums(s2_sum), .upds(s2_upd)
    );

    // Stage 3: entries of sum 4.
    srs_feed_gate #(.W(SW), .RATIO(T2A)) u_g3 (
        .clk(clk), .rst_n(rst_n), .in_upd(s2_upd[0]), .in_sum(s2_sum[0]),
        .out_vld(g3_vld), .out_val(g3_val)
    );
    srs_stage #(.W(SW), .NTAP(2), .TA(T3A), .TB(T3B), .TC(1), .TD(1)) u_st3 (
        .clk(clk), .rst_n(rst_n), .in_vld(g3_vld), .in_val(g3_val),
        .sums(s3_sum), .upds(s3_upd)
    );

    // Stage 4: entries of sum 6.
    srs_feed_gate #(.W(SW), .RATIO(T3A)) u_g4 (
        .clk(clk), .rst_n(rst_n), .in_upd(s3_upd[0]), .in_sum(s3_sum[0]),
        .out_vld(g4_vld), .out_val(g4_val)
    );
    srs_stage #(.W(SW), .NTAP(2), .TA(T4A), .TB(T4B), .TC(1), .TD(1)) u_st4 (
        .clk(clk), .rst_n(rst_n), .in_vld(g4_vld), .in_val(g4_val),
        .sums(s4_sum), .upds(s4_upd)
    );

    // Stage 5: entries of sum 7.
    srs_feed_gate #(.W(SW), .RATIO(T3B)) u_g5 (
        .clk(clk), .rst_n(rst_n), .in_upd(s3_upd[1]), .in_sum(s3_sum[1]),
        .out_vld(g5_vld), .out_val(g5_val)
    );
    srs_stage #(.W(SW), .NTAP(2), .TA(T5A), .TB(T5B), .TC(1), .TD(1)) u_st5 (
        .clk(clk), .rst_n(rst_n), .in_vld(g5_vld), .in_val(g5_val),
        .sums(s5_sum), .upds(s5_upd)
    );

    assign win_sum = {s5_sum, s4_sum, s3_sum, s2_sum, s1_sum};
    assign win_upd = {s5_upd, s4_upd, s3_upd, s2_upd, s1_upd};

    // R2
    shortest_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_upd[0] |-> (win_sum[0] == $past(smp_ext)) && $past(smp_vld));
    // R8
    idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !win_upd[0]);
    // R3
    stage2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_upd[4] |-> $past(win_upd[1]));
    // R4
    stage3_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_upd[6] |-> $past(win_upd[4]));
    // R5
    stage4_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_upd[8] |-> $past(win_upd[6]));
    // R6
    stage5_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_upd[10] |-> $past(win_upd[7]));
    // R7
    pair_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_upd[5] == win_upd[4]) && (win_upd[11] == win_upd[10]));

endmodule

// File: tb/sim_srs_cascade.sv
module sim_srs_cascade;

    localparam int DW = 8;
    localparam int SW = DW + $clog2(48) + 1;
    localparam int HMAX = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [DW-1:0] smp_val = '0;
    logic [11:0][SW-1:0] win_sum;
    logic [11:0] win_upd;

    always #5 clk = ~clk;

    srs_cascade #(
        .DW(DW), .T1A(1), .T1B(2), .T1C(4), .T1D(8),
        .T2A(2), .T2B(4), .T3A(2), .T3B(3),
        .T4A(2), .T4B(3), .T5A(2), .T5B(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_val(smp_val),
        .win_sum(win_sum), .win_upd(win_upd)
    );

    // Period, span and extra latency of each sum for the scaled depths above.
    int per [12] = '{1, 1, 1, 1, 2, 2, 4, 4, 8, 8, 12, 12};
    int spn [12] = '{1, 2, 4, 8, 4, 8, 8, 12, 16, 24, 24, 48};
    int lat [12] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3, 3, 3};

    longint hist [HMAX];
    int     hcyc [HMAX];
    int     nsmp = 0;
    int     cyc = 0;
    int     seen [12];
    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string rq(input int j);
        if (j < 4) return "R2";
        if (j < 6) return "R3";
        if (j < 8) return "R4";
        if (j < 10) return "R5";
        return "R6";
    endfunction

    function automatic longint ref_sum(input int n, input int w);
        longint e = 0;
        for (int k = n - w; k < n; k++) begin
            if (k >= 0) e += hist[k];
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Every strobe: value against the reference window, and its clock against the latency.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int j = 0; j < 12; j++) begin
                if (win_upd[j]) begin
                    int n;
                    n = (seen[j] + 1) * per[j];
                    seen[j]++;
                    if (n > nsmp) begin
                        chk(1'b0, {rq(j), " extra strobe"}, n, nsmp);
                    end else begin
                        longint act;
                        act = longint'($signed(win_sum[j]));
                        chk(act == ref_sum(n, spn[j]), {rq(j), " value"}, act, ref_sum(n, spn[j]));
                        chk(cyc == hcyc[n-1] + lat[j], {rq(j), " latency"}, cyc, hcyc[n-1] + lat[j]);
                    end
                end
            end
        end
    end

    task automatic put(input logic signed [DW-1:0] x);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_val = x;
        hist[nsmp] = longint'(x);
        hcyc[nsmp] = cyc + 1;
        nsmp++;
    endtask

    task automatic idle();
        @(negedge clk);
        smp_vld = 1'b0;
        smp_val = DW'($urandom);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        logic [11:0][SW-1:0] snap;
        bit quiet;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(win_upd == '0, "R1 strobes", longint'(win_upd), 0);
        chk(win_sum == '0, "R1 sums", longint'(win_sum[0]), 0);

        // R9: full windows of extreme negative, then extreme positive values
        for (int i = 0; i < 60; i++) put(-8'sd128);
        for (int i = 0; i < 60; i++) put(8'sd127);
        repeat (5) idle();
        chk($signed(win_sum[11]) == -48 * 128 + 0 || $signed(win_sum[11]) == 48 * 127,
            "R9 longest window", longint'($signed(win_sum[11])), 48 * 127);
        chk($signed(win_sum[3]) == 8 * 127, "R9 short window",
            longint'($signed(win_sum[3])), 8 * 127);

        // R8: valid low with random data changes nothing
        snap = win_sum;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            idle();
            if (win_upd != '0) quiet = 1'b0;
        end
        chk(quiet, "R8 no strobe while idle", 0, 0);
        chk(win_sum == snap, "R8 sums unchanged", longint'($signed(win_sum[0])),
            longint'($signed(snap[0])));

        // R2 R7: single sample after idle appears one clock later, for one clock
        put(8'sd37);
        idle();
        chk(win_upd[0] == 1'b1, "R2 strobe after sample", longint'(win_upd[0]), 1);
        idle();
        chk(win_upd[0] == 1'b0, "R7 strobe lasts one clock", longint'(win_upd[0]), 0);

        // Constrained random traffic with gaps
        while (nsmp < 2400) begin
            if (($urandom % 10) < 7) put(DW'($urandom));
            else idle();
        end
        repeat (8) idle();

        // R7: one strobe per completed block, no more, no fewer
        for (int j = 0; j < 12; j++) begin
            chk(seen[j] == nsmp / per[j], "R7 strobe count", seen[j], nsmp / per[j]);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule